// File: doc/BRIEF.md
# Byte-Wide Accumulator Processor Core

This block is a small 8-bit processor core. It has five working registers: an accumulator A and four general registers B, C, X and Y. It reads a variable-length instruction stream from a byte memory. It updates four status flags (negative, zero, signed overflow, carry). These flags can only be changed as a side effect of instructions, and only conditional branches read them. An instruction is one opcode byte. One address byte follows when the instruction touches memory, and one immediate byte follows when it needs a constant. When both are present, the address byte comes first.

The opcode splits into a 2-bit group, a 3-bit argument code and a 3-bit sub-operation. Argument codes 0 to 4 name A, B, C, X and Y. Code 5 is a direct memory byte. Codes 6 and 7 are the same byte offset by X or by Y. What code 0 means depends on the group. All control transfers are absolute.

The core runs a multi-cycle sequence: opcode fetch, address byte, immediate byte, memory read, execute, then an optional memory write. The memory port is a single byte port. It has a registered address, write data and a one-cycle write strobe. Read data must reflect the current address within the same cycle.

Top module: `acc_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, mem_we is 0 and mem_addr is 0. The first opcode is fetched from address 0.
- R2: The opcode is laid out as [7:6] group, [5:3] argument code, [2:0] sub-op. Argument codes are 0=A, 1=B, 2=C, 3=X, 4=Y, 5=direct memory, 6=memory at byte+X, 7=memory at byte+Y.
- R3: Group 0 (00) computes A = A op arg. Sub-ops are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 CMP. Argument code 0 makes the instruction a one-byte no-op.
- R4: Add and subtract forms update all four flags. C is the carry out for adds and is set when no borrow occurs for subtracts. SBC subtracts an extra 1 when C is 0. V is signed overflow. CMP sets flags like SUB but writes nothing. AND, OR and XOR update only N and Z.
- R5: Group 1 (01) computes arg = arg op immediate using the group 0 sub-ops. Code 0 means A. A memory argument is read, modified and written back.
- R6: Group 2 (10) copies arg to the destination named by the sub-op field, with no flag change. When the two codes are equal, the source is an immediate. Two different memory codes form a one-byte no-op.
- R7: Group 3 (11) sub-ops 0 to 5 are INC, DEC, SHL, SHR, ROL and ROR on arg (code 0 = A, memory is read-modify-write). INC and DEC change only N and Z. The shifts and rotates move the outgoing bit into C, and the rotates take C into the vacated bit.
- R8: Group 3 sub-op 6 jumps to an absolute target. The target is an immediate for code 0, the register value for codes 1 to 4, or the memory byte for codes 5 to 7.
- R9: Group 3 sub-op 7 is a branch with an immediate target. arg[2:1] selects the flag (0 N, 1 Z, 2 V, 3 C) and arg[0]=1 branches when that flag is set, 0 when it is clear. A branch that is not taken continues after its two bytes.
- R10: For codes 6 and 7, the effective address is the address byte plus X or Y, modulo 256.
- R11: mem_we is never high for two cycles in a row, and flags change only in the execute cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | W | Registered byte address |
| mem_wdata | output | W | Registered write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | W | Read data for the current mem_addr, valid in the same cycle |

## Verification
The checker assumes that the memory answers in the same cycle that mem_addr is presented. It also assumes that reset is asserted at least one clock edge before any other check counts. The bench meets both assumptions with a combinational-read memory model, and it loads each program only while reset is held, so no write strobe can land during loading. Random vectors draw operands and sub-ops from $urandom under a fixed seed and force the carry to a known value first. Flags are observed only through conditional branches that skip stores, because nothing outside the core can read them directly.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int NREG = 5;
  localparam logic [2:0] CODE_MEM = 3'd5;
  localparam logic [2:0] CODE_IDX_X = 3'd6;
  localparam logic [2:0] CODE_IDX_Y = 3'd7;

  localparam logic [1:0] GRP_ALU = 2'd0;
  localparam logic [1:0] GRP_IMM = 2'd1;
  localparam logic [1:0] GRP_MOV = 2'd2;
  localparam logic [1:0] GRP_UNI = 2'd3;

  localparam logic [2:0] SUB_CMP = 3'd7;
  localparam logic [2:0] SUB_JMP = 3'd6;
  localparam logic [2:0] SUB_BR = 3'd7;

  typedef enum logic [2:0] {
    ST_FETCH, ST_ADDR, ST_IMM, ST_READ, ST_EXEC, ST_WRITE
  } state_e;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_XOR, OP_CMP,
    OP_INC, OP_DEC, OP_SHL, OP_SHR, OP_ROL, OP_ROR, OP_PASS
  } alu_op_e;

  typedef struct packed {
    logic [1:0] grp;
    logic [2:0] arg;
    logic [2:0] sub;
    alu_op_e    op;
    logic       nop;
    logic       need_addr;
    logic       need_imm;
    logic       need_read;
    logic       mem_wr;
    logic       reg_wr;
    logic       is_jmp;
    logic       is_br;
    logic [2:0] mcode;
    logic [2:0] dst;
  } dec_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  logic a_mem, s_mem, same;

  always_comb begin
    a_mem = opcode[5:3] >= CODE_MEM;
    s_mem = opcode[2:0] >= CODE_MEM;
    same = opcode[5:3] == opcode[2:0];
    dec = '0;
    dec.grp = opcode[7:6];
    dec.arg = opcode[5:3];
    dec.sub = opcode[2:0];
    dec.op = OP_PASS;
    dec.mcode = opcode[5:3];
    dec.dst = opcode[5:3];
    case (opcode[7:6])
      GRP_ALU: begin
        dec.nop = opcode[5:3] == 3'd0;
        dec.op = alu_op_e'({1'b0, opcode[2:0]});
        dec.need_addr = a_mem;
        dec.need_read = a_mem;
        dec.reg_wr = (opcode[5:3] != 3'd0) && (opcode[2:0] != SUB_CMP);
        dec.dst = 3'd0;
      end
      GRP_IMM: begin
        dec.op = alu_op_e'({1'b0, opcode[2:0]});
        dec.need_imm = 1'b1;
        dec.need_addr = a_mem;
        dec.need_read = a_mem;
        dec.mem_wr = a_mem && (opcode[2:0] != SUB_CMP);
        dec.reg_wr = !a_mem && (opcode[2:0] != SUB_CMP);
      end
      GRP_MOV: begin
        dec.nop = a_mem && s_mem && !same;
        dec.need_imm = same;
        dec.need_addr = !dec.nop && (a_mem || s_mem);
        dec.mcode = s_mem ? opcode[2:0] : opcode[5:3];
        dec.need_read = !dec.nop && !same && a_mem;
        dec.mem_wr = !dec.nop && s_mem;
        dec.reg_wr = !s_mem;
        dec.dst = opcode[2:0];
      end
      default: begin
        if (opcode[2:0] == SUB_JMP) begin
          dec.is_jmp = 1'b1;
          dec.need_imm = opcode[5:3] == 3'd0;
          dec.need_addr = a_mem;
          dec.need_read = a_mem;
        end else if (opcode[2:0] == SUB_BR) begin
          dec.is_br = 1'b1;
          dec.need_imm = 1'b1;
        end else begin
          dec.op = alu_op_e'({1'b1, opcode[2:0]});
          dec.need_addr = a_mem;
          dec.need_read = a_mem;
          dec.mem_wr = a_mem;
          dec.reg_wr = !a_mem;
        end
      end
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         vout,
  output logic         upd_nz,
  output logic         upd_c,
  output logic         upd_v
);

  logic [W-1:0] yy;
  logic         ci;
  logic [W:0]   sum;

  always_comb begin
    yy = (op == OP_SUB || op == OP_SBC || op == OP_CMP) ? ~y : y;
    ci = 1'b0;
    if (op == OP_ADC || op == OP_SBC) ci = cin;
    else if (op == OP_SUB || op == OP_CMP) ci = 1'b1;
    sum = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, ci};

    res = x;
    cout = cin;
    vout = 1'b0;
    upd_nz = 1'b0;
    upd_c = 1'b0;
    upd_v = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        res = sum[W-1:0];
        cout = sum[W];
        vout = (x[W-1] == yy[W-1]) && (sum[W-1] != x[W-1]);
        upd_nz = 1'b1;
        upd_c = 1'b1;
        upd_v = 1'b1;
      end
      OP_AND: begin res = x & y; upd_nz = 1'b1; end
      OP_OR:  begin res = x | y; upd_nz = 1'b1; end
      OP_XOR: begin res = x ^ y; upd_nz = 1'b1; end
      OP_INC: begin res = x + 1'b1; upd_nz = 1'b1; end
      OP_DEC: begin res = x - 1'b1; upd_nz = 1'b1; end
      OP_SHL: begin res = {x[W-2:0], 1'b0}; cout = x[W-1]; upd_nz = 1'b1; upd_c = 1'b1; end
      OP_SHR: begin res = {1'b0, x[W-1:1]}; cout = x[0]; upd_nz = 1'b1; upd_c = 1'b1; end
      OP_ROL: begin res = {x[W-2:0], cin}; cout = x[W-1]; upd_nz = 1'b1; upd_c = 1'b1; end
      OP_ROR: begin res = {cin, x[W-1:1]}; cout = x[0]; upd_nz = 1'b1; upd_c = 1'b1; end
      default: res = x;
    endcase
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_ADDR = '0
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  input  logic [W-1:0] mem_rdata
);

  state_e       state;
  dec_t         dec_f, dec_q;
  logic [W-1:0] ip, ea, imm_q, mval;
  logic [W-1:0] rf [NREG];
  logic         fl_n, fl_z, fl_v, fl_c;

  logic [W-1:0] idx_v, srcv, alu_x, alu_y, alu_res, jtgt, next_ip;
  logic         alu_c, alu_v, upd_nz, upd_c, upd_v, br_flag, take;

  acc_decode u_dec (.opcode(mem_rdata[7:0]), .dec(dec_f));

  acc_alu #(.W(W)) u_alu (
    .op(dec_q.op), .x(alu_x), .y(alu_y), .cin(fl_c),
    .res(alu_res), .cout(alu_c), .vout(alu_v),
    .upd_nz(upd_nz), .upd_c(upd_c), .upd_v(upd_v)
  );

  always_comb begin
    case (dec_q.mcode)
      CODE_IDX_X: idx_v = rf[3];
      CODE_IDX_Y: idx_v = rf[4];
      default:    idx_v = '0;
    endcase
    case (dec_q.arg)
      3'd0: srcv = rf[0];
      3'd1: srcv = rf[1];
      3'd2: srcv = rf[2];
      3'd3: srcv = rf[3];
      3'd4: srcv = rf[4];
      default: srcv = mval;
    endcase
    alu_y = '0;
    case (dec_q.grp)
      GRP_ALU: begin alu_x = rf[0]; alu_y = srcv; end
      GRP_IMM: begin alu_x = srcv; alu_y = imm_q; end
      GRP_MOV: alu_x = (dec_q.arg == dec_q.sub) ? imm_q : srcv;
      default: alu_x = srcv;
    endcase
    jtgt = (dec_q.arg == 3'd0) ? imm_q : srcv;
    case (dec_q.arg[2:1])
      2'd0: br_flag = fl_n;
      2'd1: br_flag = fl_z;
      2'd2: br_flag = fl_v;
      default: br_flag = fl_c;
    endcase
    take = br_flag == dec_q.arg[0];
    next_ip = ip;
    if (dec_q.is_jmp) next_ip = jtgt;
    else if (dec_q.is_br && take) next_ip = imm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      ip <= RESET_ADDR;
      mem_addr <= RESET_ADDR;
      mem_wdata <= '0;
      mem_we <= 1'b0;
      dec_q <= '0;
      ea <= '0;
      imm_q <= '0;
      mval <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      fl_n <= 1'b0;
      fl_z <= 1'b0;
      fl_v <= 1'b0;
      fl_c <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      case (state)
        ST_FETCH: begin
          dec_q <= dec_f;
          ip <= ip + 1'b1;
          if (dec_f.need_addr) begin
            state <= ST_ADDR;
            mem_addr <= ip + 1'b1;
          end else if (dec_f.need_imm) begin
            state <= ST_IMM;
            mem_addr <= ip + 1'b1;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_ADDR: begin
          ea <= mem_rdata + idx_v;
          ip <= ip + 1'b1;
          if (dec_q.need_imm) begin
            state <= ST_IMM;
            mem_addr <= ip + 1'b1;
          end else if (dec_q.need_read) begin
            state <= ST_READ;
            mem_addr <= mem_rdata + idx_v;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_IMM: begin
          imm_q <= mem_rdata;
          ip <= ip + 1'b1;
          if (dec_q.need_read) begin
            state <= ST_READ;
            mem_addr <= ea;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_READ: begin
          mval <= mem_rdata;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!dec_q.nop) begin
            if (dec_q.reg_wr && (dec_q.dst < 3'(NREG))) rf[dec_q.dst] <= alu_res;
            if (upd_nz) begin
              fl_n <= alu_res[W-1];
              fl_z <= alu_res == '0;
            end
            if (upd_c) fl_c <= alu_c;
            if (upd_v) fl_v <= alu_v;
          end
          if (dec_q.mem_wr) begin
            mem_addr <= ea;
            mem_wdata <= alu_res;
            mem_we <= 1'b1;
            state <= ST_WRITE;
          end else begin
            ip <= next_ip;
            mem_addr <= next_ip;
            state <= ST_FETCH;
          end
        end
        ST_WRITE: begin
          mem_addr <= ip;
          state <= ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_ADDR = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input state_e       state,
  input logic [3:0]   flags,
  input alu_op_e      op,
  input logic         nop
);

  logic incdec_exec;
  assign incdec_exec = (state == ST_EXEC) && !nop && (op == OP_INC || op == OP_DEC);

  assert_reset_port_R1: assert property (@(posedge clk)
    rst |=> (mem_addr == RESET_ADDR && !mem_we));

  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_we_in_write_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_WRITE));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXEC) |=> $stable(flags));

  assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (rst)
    incdec_exec |=> $stable(flags[0]));

endmodule

bind acc_core acc_core_chk #(.W(W), .RESET_ADDR(RESET_ADDR)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .state(state), .flags({fl_n, fl_z, fl_v, fl_c}), .op(dec_q.op), .nop(dec_q.nop)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we;
  logic [7:0] mem [256];
  int nchk = 0, nfail = 0, pc = 0;
  int we_prev = 0, we_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] = mem_wdata;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (we_prev != 0) we_bad++;
      we_prev = 1;
    end else we_prev = 0;
  end

  acc_core #(.W(W)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] enc(input int g, input int a, input int s);
    return {g[1:0], a[2:0], s[2:0]};
  endfunction

  task automatic put(input logic [7:0] b);
    mem[pc] = b;
    pc++;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    pc = 0;
  endtask

  task automatic launch(input int ncyc);
    @(negedge clk);
    rst = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {n,z,v,c,result}; flags before the op: v=0, c=cin
  function automatic logic [11:0] ref_op(input int opc, input int x, input int y, input logic cin);
    int s, r, sv;
    logic n, z, v, c;
    v = 1'b0; c = cin; r = 0;
    case (opc)
      0: begin s = x + y; c = s > 255; sv = sgn(x) + sgn(y); v = sv > 127 || sv < -128; r = s & 255; end
      1: begin s = x + y + int'(cin); c = s > 255; sv = sgn(x) + sgn(y) + int'(cin);
               v = sv > 127 || sv < -128; r = s & 255; end
      2, 7: begin s = x - y; c = s >= 0; sv = sgn(x) - sgn(y); v = sv > 127 || sv < -128; r = s & 255; end
      3: begin s = x - y - (cin ? 0 : 1); c = s >= 0; sv = sgn(x) - sgn(y) - (cin ? 0 : 1);
               v = sv > 127 || sv < -128; r = s & 255; end
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      8: r = (x + 1) & 255;
      9: r = (x + 255) & 255;
      10: begin c = x >= 128; r = (x * 2) & 255; end
      11: begin c = (x % 2) == 1; r = x / 2; end
      12: begin c = x >= 128; r = ((x * 2) & 255) + int'(cin); end
      default: begin c = (x % 2) == 1; r = x / 2 + (cin ? 128 : 0); end
    endcase
    n = r >= 128;
    z = r == 0;
    return {n, z, v, c, 8'(r)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int l_br1, l_br2, l_jc, l_nt, t;
    logic [11:0] e;
    void'($urandom(32'd7171));

    // R1: reset state at the port
    hold_reset();
    chk("R1 mem_we in reset", int'(mem_we), 0);
    chk("R1 mem_addr in reset", int'(mem_addr), 0);

    // random and corner ALU / single-operand vectors (R3 R4 R7 R9)
    for (int k = 0; k < NVEC; k++) begin
      int kind, sub, x, y, opc, cv;
      kind = int'($urandom % 2);
      sub = kind ? int'($urandom % 6) : int'($urandom % 8);
      x = int'($urandom % 256);
      y = int'($urandom % 256);
      cv = int'($urandom % 2);
      if (k == 0) begin kind = 0; sub = 0; x = 8'h7F; y = 8'h01; end
      if (k == 1) begin kind = 0; sub = 2; x = 8'h80; y = 8'h01; end
      if (k == 2) begin kind = 0; sub = 1; x = 8'hFF; y = 8'h00; cv = 1; end
      if (k == 3) begin kind = 0; sub = 7; x = 8'h00; y = 8'h00; end
      if (k == 4) begin kind = 0; sub = 3; x = 8'h00; y = 8'h00; cv = 0; end
      if (k == 5) begin kind = 1; sub = 5; x = 8'h01; cv = 1; end
      opc = kind ? 8 + sub : sub;
      hold_reset();
      put(enc(2, 0, 0)); put(8'(x));
      put(enc(2, 1, 1)); put(8'(y));
      put(enc(2, 2, 2)); put(8'(cv));
      put(enc(3, 2, 3));
      put(kind ? enc(3, 0, sub) : enc(0, 1, sub));
      put(enc(2, 0, 5)); put(8'hF0);
      for (int f = 0; f < 4; f++) begin
        put(enc(3, f * 2, 7)); put(8'(pc + 4));
        put(enc(2, 5, 5)); put(8'(8'hF1 + f)); put(8'h01);
      end
      put(enc(3, 0, 6)); put(8'(pc - 1));
      launch(200);
      e = ref_op(opc, x, y, cv[0]);
      chk(kind ? "R7 result" : "R3 result", int'(mem[8'hF0]), (opc == 7) ? x : int'(e[7:0]));
      chk("R4 R9 flag N", int'(mem[8'hF1]), int'(e[11]));
      chk("R4 R9 flag Z", int'(mem[8'hF2]), int'(e[10]));
      chk("R4 R9 flag V", int'(mem[8'hF3]), int'(e[9]));
      chk("R4 R7 flag C", int'(mem[8'hF4]), int'(e[8]));
    end

    // directed program
    hold_reset();
    mem[8'h80] = 8'h05; mem[8'h81] = 8'h06; mem[8'h82] = 8'h07; mem[8'h83] = 8'h3C;
    put(enc(2, 3, 3)); put(8'h03);
    put(enc(2, 4, 4)); put(8'h01);
    put(enc(2, 0, 0)); put(8'h10);
    put(enc(0, 6, 0)); put(8'h80);
    put(enc(2, 0, 5)); put(8'hF0);
    put(enc(2, 7, 1)); put(8'h80);
    put(enc(1, 1, 0)); put(8'h20);
    put(enc(2, 1, 5)); put(8'hF1);
    put(enc(2, 0, 0)); put(8'hFF);
    put(enc(1, 0, 0)); put(8'h01);
    put(enc(3, 3, 7)); l_br1 = pc; put(8'h00);
    put(enc(2, 5, 5)); put(8'hF7); put(8'hEE);
    mem[l_br1] = 8'(pc);
    put(enc(3, 0, 0));
    put(enc(1, 0, 1)); put(8'h00);
    put(enc(2, 0, 5)); put(8'hF2);
    l_nt = pc;
    put(enc(3, 7, 7)); put(8'(l_nt));
    put(enc(2, 5, 5)); put(8'hF9); put(8'h11);
    put(enc(0, 0, 3));
    put(enc(2, 5, 6));
    put(enc(3, 5, 0)); put(8'h82);
    put(enc(1, 5, 4)); put(8'h83); put(8'h0F);
    put(enc(2, 5, 5)); put(8'hF3); put(8'h5A);
    put(enc(2, 2, 2)); l_jc = pc; put(8'h00);
    put(enc(3, 2, 6));
    put(enc(2, 5, 5)); put(8'hF4); put(8'hEE);
    mem[l_jc] = 8'(pc);
    put(enc(2, 5, 5)); put(8'hF5); put(8'h77);
    put(enc(3, 5, 6)); put(8'h84);
    put(enc(2, 5, 5)); put(8'hF6); put(8'hEE);
    l_br2 = pc;
    mem[8'h84] = 8'(l_br2);
    put(enc(2, 5, 5)); put(8'hF8); put(8'h99);
    t = pc;
    put(enc(3, 0, 6)); put(8'(t));
    chk("R1 first fetch address", int'(mem_addr), 0);
    launch(500);
    chk("R2 R10 add indexed by X", int'(mem[8'hF0]), 8'h4C);
    chk("R5 R10 imm op on B after indexed-Y load", int'(mem[8'hF1]), 8'h26);
    chk("R9 branch on Z set taken", int'(mem[8'hF7]), 0);
    chk("R7 INC keeps carry for ADC", int'(mem[8'hF2]), 8'h02);
    chk("R9 branch on C set not taken", int'(mem[8'hF9]), 8'h11);
    chk("R3 R6 R7 no-ops one byte then memory INC", int'(mem[8'h82]), 8'h08);
    chk("R5 memory read-modify-write AND", int'(mem[8'h83]), 8'h0C);
    chk("R6 immediate to memory", int'(mem[8'hF3]), 8'h5A);
    chk("R8 register jump skips store", int'(mem[8'hF4]), 0);
    chk("R8 register jump target runs", int'(mem[8'hF5]), 8'h77);
    chk("R8 memory jump skips store", int'(mem[8'hF6]), 0);
    chk("R8 memory jump target runs", int'(mem[8'hF8]), 8'h99);
    chk("R11 write strobe single cycle", we_bad, 0);

    summary();
    $finish;
  end

endmodule